// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the system-control register file of a processor core module. It holds the oscillator, auxiliary-oscillator, SDRAM and initialisation settings. The two oscillator words are guarded by a 16-bit key register: they accept writes only while the key register holds the unlock value. The block also keeps two flag words, a volatile one and a non-volatile one. Each has its own set address and its own clear address.

A control word drives two board-level outputs. One bit selects what appears in the low memory region: boot flash or RAM. Another bit drives a status LED. A small interrupt unit holds one software-driven interrupt source and two independent enable masks, one feeding a normal interrupt line and one feeding a fast interrupt line. An upper window of the address space returns memory-module serial presence bytes, one byte in the low bits of each word. The byte that reports module density is derived from a memory-size parameter.

Software reaches everything through a word-addressed bus with separate read and write strobes. Read data is registered and appears the cycle after the strobe. A one-cycle error pulse flags any access to a word that does not support that access.

Top module: `cm_sysctl`

## Requirements
- R1: Writing word 5 stores only `wdata[15:0]` as the key. Reading word 5 returns the key in bits 15:0 and sets bit 16 exactly when the stored key equals 0xA05F. All other bits read as 0.
- R2: Writes to word 0 (oscillator) and word 7 (auxiliary oscillator) change the register only while the stored key equals 0xA05F. Otherwise the register keeps its value and no error is raised.
- R3: After reset these words read as follows: word 0 = 0x01000048, word 7 = 0x0007FEFF, word 8 = 0x00011122, word 9 = 0x00000112. Every other register is 0. Words 8 and 9 are plain read/write.
- R4: A write to word 12 ORs `wdata` into the flag word, and a write to word 13 clears the bits set in `wdata`. Word 12 reads the flag word. The non-volatile flags behave the same way at words 14 (set, read) and 15 (clear).
- R5: Word 3 is an 8-bit control register that reads back in bits 7:0. Bit 2 drives `remap_o` (1 = RAM in the low region, 0 = boot flash). Bit 0 drives `led_o`. Both outputs change on the clock edge that takes the write.
- R6: A write to word 18 ORs `wdata` into the IRQ enable mask, and a write to word 19 clears the bits set in `wdata`. Word 18 reads the mask. The FIQ mask works the same way at words 26 (set, read) and 27 (clear).
- R7: The software interrupt level is a single bit. It is set by a write to word 20 with `wdata[0]=1` and cleared by a write to word 21 with `wdata[0]=1`; the other data bits have no effect. Words 20, 17 and 25 each read the level in bit 0.
- R8: Word 16 reads level AND IRQ mask bit 0. Word 24 reads level AND FIQ mask bit 0. Both values appear in bit 0.
- R9: `irq_o` equals level AND IRQ mask bit 0, and `fiq_o` equals level AND FIQ mask bit 0. Each is registered and updated on the same edge as the state change that moves it.
- R10: Reads of words 64 to 127 return `{24'b0, byte[word-64]}` from the presence table. Byte 31 encodes density from MEM_MB: 64 for at least 256, 32 for at least 128, 16 for at least 64, 4 for at least 32, and 2 otherwise. Bytes beyond 31 are 0. Writes to the window change nothing.
- R11: `rdata_o` is 0 in the cycle after any cycle without `rd_en`. A read of an unsupported word returns 0. Any read or write to a word that does not support that access leaves all state unchanged and raises `err_o` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Word address |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an unsupported access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| remap_o | output | 1 | Low region select: 1 = RAM, 0 = boot flash |
| led_o | output | 1 | Status LED drive |

## Verification
The hardest state to reach is an unlocked oscillator write. It needs a key write carrying exactly 0xA05F in its low half, with arbitrary upper bits, followed by an oscillator write before any other key write. Random traffic almost never produces that pair. The directed phase therefore writes the key with junk in the upper half, writes both oscillator words, relocks, and retries. The random phase then gives half of all key writes the exact key, so unlocked and locked oscillator writes interleave with flag, mask and interrupt traffic. A behavioural model checks every output on every cycle.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 7;
    localparam int unsigned CTRL_W   = 8;
    localparam int unsigned KEY_W    = 16;
    localparam int unsigned SPD_IDXW = ADDR_W - 1;
    localparam int unsigned BYTE_W   = 8;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

    localparam waddr_t A_OSC    = 7'd0;
    localparam waddr_t A_CTRL   = 7'd3;
    localparam waddr_t A_KEY    = 7'd5;
    localparam waddr_t A_AUX    = 7'd7;
    localparam waddr_t A_SDRAM  = 7'd8;
    localparam waddr_t A_INIT   = 7'd9;
    localparam waddr_t A_FSET   = 7'd12;
    localparam waddr_t A_FCLR   = 7'd13;
    localparam waddr_t A_NVSET  = 7'd14;
    localparam waddr_t A_NVCLR  = 7'd15;
    localparam waddr_t A_ISTAT  = 7'd16;
    localparam waddr_t A_IRAW   = 7'd17;
    localparam waddr_t A_IENS   = 7'd18;
    localparam waddr_t A_IENC   = 7'd19;
    localparam waddr_t A_SWSET  = 7'd20;
    localparam waddr_t A_SWCLR  = 7'd21;
    localparam waddr_t A_FQSTAT = 7'd24;
    localparam waddr_t A_FQRAW  = 7'd25;
    localparam waddr_t A_FQENS  = 7'd26;
    localparam waddr_t A_FQENC  = 7'd27;

    typedef struct packed {
        word_t              osc;
        word_t              aux;
        logic [KEY_W-1:0]   key;
        word_t              sdram;
        word_t              init;
        logic [CTRL_W-1:0]  ctrl;
        word_t              flags;
        word_t              nvflags;
    } cfg_state_t;

    typedef struct packed {
        logic  level;
        word_t irq_en;
        word_t fiq_en;
        logic  irq;
        logic  fiq;
    } irq_state_t;

    typedef struct packed {
        word_t rdata;
        logic  err;
    } bus_state_t;
endpackage

// File: rtl/cm_cfg_regs.sv
module cm_cfg_regs
    import cm_sysctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  waddr_t addr,
    input  word_t  wdata,
    output word_t  rd_data,
    output logic   rd_ok,
    output logic   wr_ok,
    output logic   remap_o,
    output logic   led_o
);
    localparam cfg_state_t CFG_RST = '{
        osc:     32'h0100_0048,
        aux:     32'h0007_FEFF,
        key:     '0,
        sdram:   32'h0001_1122,
        init:    32'h0000_0112,
        ctrl:    '0,
        flags:   '0,
        nvflags: '0
    };

    cfg_state_t q, d;
    logic       unlocked;

    assign unlocked = (q.key == UNLOCK_KEY);

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                A_OSC:   if (unlocked) d.osc = wdata;
                A_AUX:   if (unlocked) d.aux = wdata;
                A_KEY:   d.key     = wdata[KEY_W-1:0];
                A_CTRL:  d.ctrl    = wdata[CTRL_W-1:0];
                A_SDRAM: d.sdram   = wdata;
                A_INIT:  d.init    = wdata;
                A_FSET:  d.flags   = q.flags | wdata;
                A_FCLR:  d.flags   = q.flags & ~wdata;
                A_NVSET: d.nvflags = q.nvflags | wdata;
                A_NVCLR: d.nvflags = q.nvflags & ~wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        rd_ok   = 1'b1;
        case (addr)
            A_OSC:   rd_data = q.osc;
            A_AUX:   rd_data = q.aux;
            A_KEY:   rd_data = {{(DATA_W-KEY_W-1){1'b0}}, unlocked, q.key};
            A_CTRL:  rd_data = {{(DATA_W-CTRL_W){1'b0}}, q.ctrl};
            A_SDRAM: rd_data = q.sdram;
            A_INIT:  rd_data = q.init;
            A_FSET:  rd_data = q.flags;
            A_NVSET: rd_data = q.nvflags;
            default: rd_ok   = 1'b0;
        endcase
    end

    always_comb begin
        case (addr)
            A_OSC, A_AUX, A_KEY, A_CTRL, A_SDRAM, A_INIT,
            A_FSET, A_FCLR, A_NVSET, A_NVCLR: wr_ok = 1'b1;
            default:                          wr_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CFG_RST;
        else        q <= d;
    end

    assign remap_o = q.ctrl[2];
    assign led_o   = q.ctrl[0];

    AST_KEY_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY) |=> (q.key == $past(wdata[KEY_W-1:0]))); // R1
    AST_OSC_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OSC && q.key != UNLOCK_KEY) |=> $stable(q.osc)); // R2
    AST_AUX_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_AUX && q.key != UNLOCK_KEY) |=> $stable(q.aux)); // R2
    AST_FLAG_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FSET) |=> ((q.flags & $past(wdata)) == $past(wdata))); // R4
    AST_FLAG_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FCLR) |=> ((q.flags & $past(wdata)) == '0)); // R4
    AST_CTRL_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL) |=> (remap_o == $past(wdata[2]) && led_o == $past(wdata[0]))); // R5
endmodule

// File: rtl/cm_irq_unit.sv
module cm_irq_unit
    import cm_sysctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  waddr_t addr,
    input  word_t  wdata,
    output word_t  rd_data,
    output logic   rd_ok,
    output logic   wr_ok,
    output logic   irq_o,
    output logic   fiq_o
);
    irq_state_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                A_IENS:  d.irq_en = q.irq_en | wdata;
                A_IENC:  d.irq_en = q.irq_en & ~wdata;
                A_FQENS: d.fiq_en = q.fiq_en | wdata;
                A_FQENC: d.fiq_en = q.fiq_en & ~wdata;
                A_SWSET: d.level  = q.level | wdata[0];
                A_SWCLR: d.level  = q.level & ~wdata[0];
                default: ;
            endcase
        end
        d.irq = d.level & d.irq_en[0];
        d.fiq = d.level & d.fiq_en[0];
    end

    always_comb begin
        rd_data = '0;
        rd_ok   = 1'b1;
        case (addr)
            A_ISTAT:         rd_data[0] = q.level & q.irq_en[0];
            A_FQSTAT:        rd_data[0] = q.level & q.fiq_en[0];
            A_IRAW, A_FQRAW,
            A_SWSET:         rd_data[0] = q.level;
            A_IENS:          rd_data    = q.irq_en;
            A_FQENS:         rd_data    = q.fiq_en;
            default:         rd_ok      = 1'b0;
        endcase
    end

    always_comb begin
        case (addr)
            A_IENS, A_IENC, A_FQENS, A_FQENC, A_SWSET, A_SWCLR: wr_ok = 1'b1;
            default:                                           wr_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_o = q.irq;
    assign fiq_o = q.fiq;

    AST_IRQ_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IENC) |=> ((q.irq_en & $past(wdata)) == '0)); // R6
    AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SWSET && wdata[0]) |=> q.level); // R7
    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SWCLR && wdata[0]) |=> !q.level); // R7
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (q.level & q.irq_en[0])); // R9
    AST_FIQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (q.level & q.fiq_en[0])); // R9
endmodule

// File: rtl/cm_spd_rom.sv
module cm_spd_rom
    import cm_sysctl_pkg::*;
#(
    parameter int unsigned MEM_MB = 128
) (
    input  logic [SPD_IDXW-1:0] idx,
    output logic [BYTE_W-1:0]   byte_o
);
    localparam logic [BYTE_W-1:0] DENSITY =
        (MEM_MB >= 256) ? 8'd64 :
        (MEM_MB >= 128) ? 8'd32 :
        (MEM_MB >= 64)  ? 8'd16 :
        (MEM_MB >= 32)  ? 8'd4  : 8'd2;

    always_comb begin
        case (idx)
            6'd0:  byte_o = 8'd128;
            6'd1:  byte_o = 8'd8;
            6'd2:  byte_o = 8'd4;
            6'd3:  byte_o = 8'd11;
            6'd4:  byte_o = 8'd9;
            6'd5:  byte_o = 8'd1;
            6'd6:  byte_o = 8'd64;
            6'd8:  byte_o = 8'd2;
            6'd9,
            6'd10: byte_o = 8'hA0;
            6'd13: byte_o = 8'd8;
            6'd15: byte_o = 8'd1;
            6'd16: byte_o = 8'h0E;
            6'd17: byte_o = 8'd4;
            6'd18: byte_o = 8'h1C;
            6'd19: byte_o = 8'd1;
            6'd20: byte_o = 8'd2;
            6'd21: byte_o = 8'h20;
            6'd22: byte_o = 8'hC0;
            6'd27,
            6'd29: byte_o = 8'h30;
            6'd28,
            6'd30: byte_o = 8'h28;
            6'd31: byte_o = DENSITY;
            default: byte_o = 8'd0;
        endcase
    end
endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
    import cm_sysctl_pkg::*;
#(
    parameter int unsigned MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              remap_o,
    output logic              led_o
);
    word_t              cfg_rd, irq_rd;
    logic               cfg_rd_ok, cfg_wr_ok, irq_rd_ok, irq_wr_ok;
    logic [BYTE_W-1:0]  spd_byte;
    logic               spd_hit, rd_ok, wr_ok;
    bus_state_t         q, d;

    cm_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(cfg_rd), .rd_ok(cfg_rd_ok), .wr_ok(cfg_wr_ok),
        .remap_o(remap_o), .led_o(led_o)
    );

    cm_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(irq_rd), .rd_ok(irq_rd_ok), .wr_ok(irq_wr_ok),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    cm_spd_rom #(.MEM_MB(MEM_MB)) u_spd (
        .idx(addr[SPD_IDXW-1:0]), .byte_o(spd_byte)
    );

    assign spd_hit = addr[ADDR_W-1];
    assign rd_ok   = spd_hit | cfg_rd_ok | irq_rd_ok;
    assign wr_ok   = cfg_wr_ok | irq_wr_ok;

    always_comb begin
        d.rdata = '0;
        if (rd_en) begin
            if (spd_hit)        d.rdata = {{(DATA_W-BYTE_W){1'b0}}, spd_byte};
            else if (cfg_rd_ok) d.rdata = cfg_rd;
            else if (irq_rd_ok) d.rdata = irq_rd;
        end
        d.err = (rd_en && !rd_ok) || (wr_en && !wr_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.rdata;
    assign err_o   = q.err;

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(rd_en || wr_en)); // R11
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata_o == '0)); // R11
    AST_SPD_BYTE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1]) |=> (rdata_o[DATA_W-1:BYTE_W] == '0)); // R10
endmodule

// File: tb/cm_sysctl_tb_top.sv
module cm_sysctl_tb_top;
    localparam int MEM_MB = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_o;
    logic        err_o, irq_o, fiq_o, remap_o, led_o;

    int n_cmp = 0, n_bad = 0;

    bit [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_ien, m_fen;
    bit [15:0] m_key;
    bit [7:0]  m_ctrl;
    bit        m_lvl;

    always #4 clk = ~clk;

    cm_sysctl #(.MEM_MB(MEM_MB)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata_o(rdata_o), .err_o(err_o), .irq_o(irq_o),
        .fiq_o(fiq_o), .remap_o(remap_o), .led_o(led_o)
    );

    function automatic bit [7:0] spd_ref(int i);
        bit [7:0] hdr [32] = '{128, 8, 4, 11, 9, 1, 64, 0, 2, 8'hA0, 8'hA0, 0, 0, 8, 0, 1,
                               8'h0E, 4, 8'h1C, 1, 2, 8'h20, 8'hC0, 0, 0, 0, 0,
                               8'h30, 8'h28, 8'h30, 8'h28, 0};
        if (i == 31) return (MEM_MB >= 256) ? 8'd64 : (MEM_MB >= 128) ? 8'd32 :
                            (MEM_MB >= 64) ? 8'd16 : (MEM_MB >= 32) ? 8'd4 : 8'd2;
        if (i < 32) return hdr[i];
        return 8'd0;
    endfunction

    function automatic bit rd_known(int a);
        return (a >= 64) || (a inside {0, 3, 5, 7, 8, 9, 12, 14, 16, 17, 18, 20, 24, 25, 26});
    endfunction

    function automatic bit wr_known(int a);
        return a inside {0, 3, 5, 7, 8, 9, 12, 13, 14, 15, 18, 19, 20, 21, 26, 27};
    endfunction

    function automatic bit [31:0] rd_val(int a);
        if (a >= 64) return {24'd0, spd_ref(a - 64)};
        case (a)
            0:  return m_osc;
            3:  return {24'd0, m_ctrl};
            5:  return {15'd0, (m_key == 16'hA05F), m_key};
            7:  return m_aux;
            8:  return m_sdram;
            9:  return m_init;
            12: return m_flags;
            14: return m_nv;
            16: return {31'd0, m_lvl & m_ien[0]};
            17, 20, 25: return {31'd0, m_lvl};
            18: return m_ien;
            24: return {31'd0, m_lvl & m_fen[0]};
            26: return m_fen;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(int a, bit [31:0] v);
        case (a)
            0:  if (m_key == 16'hA05F) m_osc = v;
            7:  if (m_key == 16'hA05F) m_aux = v;
            5:  m_key = v[15:0];
            3:  m_ctrl = v[7:0];
            8:  m_sdram = v;
            9:  m_init = v;
            12: m_flags |= v;
            13: m_flags &= ~v;
            14: m_nv |= v;
            15: m_nv &= ~v;
            18: m_ien |= v;
            19: m_ien &= ~v;
            26: m_fen |= v;
            27: m_fen &= ~v;
            20: if (v[0]) m_lvl = 1'b1;
            21: if (v[0]) m_lvl = 1'b0;
            default: ;
        endcase
    endtask

    function automatic string tag_of(int a);
        if (a >= 64) return "R10";
        case (a)
            0, 7:        return "R2";
            5:           return "R1";
            8, 9:        return "R3";
            12, 14:      return "R4";
            3:           return "R5";
            18, 26:      return "R6";
            17, 20, 25:  return "R7";
            16, 24:      return "R8";
            default:     return "R11";
        endcase
    endfunction

    task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit w, bit r, int a, bit [31:0] v);
        bit [31:0] e_rd;
        bit        e_err;
        wr_en = w; rd_en = r; addr = 7'(a); wdata = v;
        e_rd  = (r && rd_known(a)) ? rd_val(a) : 32'd0;
        e_err = (r && !rd_known(a)) || (w && !wr_known(a));
        if (w) model_write(a, v);
        @(negedge clk);
        check(r ? tag_of(a) : "R11", rdata_o, e_rd);
        check("R11", {31'd0, err_o}, {31'd0, e_err});
        check("R9",  {31'd0, irq_o}, {31'd0, m_lvl & m_ien[0]});
        check("R9",  {31'd0, fiq_o}, {31'd0, m_lvl & m_fen[0]});
        check("R5",  {31'd0, remap_o}, {31'd0, m_ctrl[2]});
        check("R5",  {31'd0, led_o}, {31'd0, m_ctrl[0]});
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(int a, bit [31:0] v); cyc(1'b1, 1'b0, a, v); endtask
    task automatic rd(int a);               cyc(1'b0, 1'b1, a, 32'd0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF;
        m_sdram = 32'h0001_1122; m_init = 32'h0000_0112;
        m_key = '0; m_ctrl = '0; m_flags = '0; m_nv = '0;
        m_ien = '0; m_fen = '0; m_lvl = 1'b0;
        repeat (3) @(negedge clk);
        // reset state of outputs (R5, R9, R11)
        check("R11", rdata_o, 32'd0);
        check("R11", {31'd0, err_o}, 32'd0);
        check("R9",  {30'd0, irq_o, fiq_o}, 32'd0);
        check("R5",  {30'd0, remap_o, led_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset values of every low word, errors on unsupported reads
        for (int a = 0; a < 32; a++) rd(a);

        // R2 locked, R1 key handling
        wr(0, 32'h1234_5678); rd(0);
        wr(5, 32'hFFFF_A05F); rd(5);
        wr(0, 32'hCAFE_0001); rd(0);
        wr(7, 32'h0000_BEEF); rd(7);
        wr(5, 32'h0000_A05E); rd(5);
        wr(7, 32'h1111_1111); rd(7);
        wr(8, 32'hDEAD_BEEF); rd(8);
        wr(9, 32'h0000_0ABC); rd(9);

        // R4 flags
        wr(12, 32'h0000_F0F0); wr(12, 32'h0000_0F00); wr(13, 32'h0000_00F0); rd(12);
        wr(14, 32'h8000_0001); wr(15, 32'h0000_0001); rd(14);

        // R5 control outputs
        wr(3, 32'hFFFF_FF05); rd(3);
        wr(3, 32'h0000_0004); wr(3, 32'h0000_0001); wr(3, 32'h0); rd(3);

        // R6, R7, R8, R9 interrupt unit
        wr(20, 32'h1); rd(17); rd(16);
        wr(18, 32'h0000_0003); rd(16); rd(18);
        wr(26, 32'h0000_0001); rd(24); rd(25);
        wr(21, 32'hFFFF_FFFE); rd(20);
        wr(21, 32'h1); rd(16);
        wr(20, 32'hFFFF_FFFE); rd(20);
        wr(20, 32'h1); wr(19, 32'h1); rd(18); wr(27, 32'h1); rd(26);

        // R10 presence window, R11 illegal writes
        for (int a = 64; a < 128; a++) rd(a);
        wr(70, 32'hFFFF_FFFF); rd(70);
        wr(16, 32'hFFFF_FFFF); rd(16);
        wr(1, 32'h5); rd(19);
        cyc(1'b1, 1'b1, 12, 32'h0100_0000); rd(12);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int a;
            bit [31:0] v;
            a = ($urandom % 4 == 0) ? 64 + int'($urandom % 64) : int'($urandom % 32);
            v = $urandom;
            if (a == 5 && ($urandom % 2)) v = {v[31:16], 16'hA05F};
            cyc(1'($urandom), 1'($urandom), a, v);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule